// File: doc/BRIEF.md
# Prioritized Interrupt Source Router

The router collects a large set of level-sensitive peripheral interrupt sources and steers each one, through its own routing register, onto one of a small set of numbered CPU interrupt lines. Every line has an enable bit and a 4-bit priority. A global threshold decides which priorities are high enough to reach the core. The block keeps a pending bit per line and drives a single interrupt request, carrying a cause code, towards the core.

A source that rises on a deliverable line goes straight to the core when the core's global interrupt enable is set and no request is outstanding. In every other case the line is left pending. Pending lines are reconsidered only when the core's global enable turns on. At that moment the router delivers the best eligible pending line. A line shared by several sources stays pending until every one of those sources has dropped. Four software-trigger registers, in a separate system register space, let firmware drive four of the sources directly.

Top module: `irq_router`

## Requirements
- R1: After reset every register reads zero, no line is pending and `irq_req_o` is low.
- R2: In the matrix space (`reg_space_i`=0), the following registers read back as follows. Source maps sit at 0x000+4·s for sources 0..61 and keep 5 bits. The enable bitmap at 0x104 and the line-type word at 0x108 keep 32 bits. Priorities sit at 0x114+4·line and keep 4 bits; line 0's priority always reads 0. The threshold at 0x194 keeps 4 bits. The pending bitmap at 0x10C ignores writes. Any other offset reads zero.
- R3: A routed source rises while its line is enabled, the line's priority exceeds the threshold, `core_mie_i` is 1 and no request is outstanding. On the next edge `irq_req_o` rises with cause bit 31 set and the line number in bits 4:0, and the line does not become pending.
- R4: The threshold comparison is strict. A line whose priority equals the threshold is not delivered and becomes pending; a threshold one lower lets it through.
- R5: A source that rises on a disabled line, or while `core_mie_i` is 0, sets the line's pending bit and raises no request.
- R6: A source mapped to line 0 is ignored: no pending bit and no request.
- R7: A line's pending bit clears once no active source maps to it, and not before.
- R8: When `core_mie_i` goes from 0 to 1 with no request outstanding, the router considers the pending lines that are enabled and above threshold. It delivers the one with the highest priority, taking the lowest line number on a tie, and clears that line's pending bit. Pending lines that are disabled stay pending.
- R9: `irq_req_o` and its cause hold until `irq_ack_i` is 1 at a clock edge, which clears the request. A source that rises while a request is outstanding only sets its line's pending bit.
- R10: In the system space (`reg_space_i`=1), bit 0 of the words at 0x028, 0x02C, 0x030 and 0x034 drives sources 28, 29, 30 and 31. Writing 1 raises the source and writing 0 lowers it. The bit reads back, and other system offsets read zero.
- R11: When several eligible lines rise together, the best one by the R8 rule is delivered and the others become pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_space_i | input | 1 | 0 = matrix space, 1 = system space |
| reg_addr_i | input | 12 | Byte offset in the selected space |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| src_i | input | 62 | Hardware interrupt source levels |
| core_mie_i | input | 1 | Core global interrupt enable |
| irq_ack_i | input | 1 | Core acknowledge of the current request |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_cause_o | output | 32 | Cause code of the current request |

## Verification
Some properties are checked on every cycle. The request must hold with a stable cause until it is acknowledged, and must drop right after an acknowledge. Any cause presented must carry bit 31 and a nonzero line number. A request may only start after a cycle in which the global enable was set. Line 0 must never become pending. The ordering rules need the bench's scenarios: priority against threshold, the lowest-line tie break, the rescan when the global enable turns on, shared lines waiting for their last source, and the software triggers.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;

  typedef enum logic {
    SPACE_MATRIX = 1'b0,
    SPACE_SYSTEM = 1'b1
  } reg_space_e;

  localparam logic [ADDR_W-1:0] OFF_ENABLE = 12'h104;
  localparam logic [ADDR_W-1:0] OFF_TYPE   = 12'h108;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 12'h10C;
  localparam logic [ADDR_W-1:0] OFF_PRIO   = 12'h114;
  localparam logic [ADDR_W-1:0] OFF_THRESH = 12'h194;
  localparam logic [ADDR_W-1:0] OFF_SWI    = 12'h028;
endpackage

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC  = 62,
  parameter int unsigned LINE_W = 5,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned N_SWI  = 4,
  localparam int unsigned N_LINE = 1 << LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              space_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_LINE-1:0] pend_i,
  output logic [LINE_W-1:0] map_o [N_SRC],
  output logic [N_LINE-1:0] en_o,
  output logic [PRIO_W-1:0] prio_o [N_LINE],
  output logic [PRIO_W-1:0] thr_o,
  output logic [N_SWI-1:0]  swi_o
);
  logic [LINE_W-1:0] map_q [N_SRC];
  logic [PRIO_W-1:0] prio_q [N_LINE];
  logic [N_LINE-1:0] en_q;
  logic [DATA_W-1:0] type_q;
  logic [PRIO_W-1:0] thr_q;
  logic [N_SWI-1:0]  swi_q;

  logic wr_mat, wr_sys;
  assign wr_mat = req_i & we_i & (space_i == SPACE_MATRIX);
  assign wr_sys = req_i & we_i & (space_i == SPACE_SYSTEM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_SRC; s++) map_q[s] <= '0;
      for (int l = 0; l < N_LINE; l++) prio_q[l] <= '0;
      en_q   <= '0;
      type_q <= '0;
      thr_q  <= '0;
      swi_q  <= '0;
    end else begin
      if (wr_mat) begin
        for (int s = 0; s < N_SRC; s++)
          if (addr_i == ADDR_W'(4 * s)) map_q[s] <= wdata_i[LINE_W-1:0];
        // line 0 carries no priority
        for (int l = 1; l < N_LINE; l++)
          if (addr_i == OFF_PRIO + ADDR_W'(4 * l)) prio_q[l] <= wdata_i[PRIO_W-1:0];
        if (addr_i == OFF_ENABLE) en_q   <= wdata_i[N_LINE-1:0];
        if (addr_i == OFF_TYPE)   type_q <= wdata_i;
        if (addr_i == OFF_THRESH) thr_q  <= wdata_i[PRIO_W-1:0];
      end
      if (wr_sys) begin
        for (int k = 0; k < N_SWI; k++)
          if (addr_i == OFF_SWI + ADDR_W'(4 * k)) swi_q[k] <= wdata_i[0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (space_i == SPACE_MATRIX) begin
      for (int s = 0; s < N_SRC; s++)
        if (addr_i == ADDR_W'(4 * s)) rdata_o = DATA_W'(map_q[s]);
      for (int l = 1; l < N_LINE; l++)
        if (addr_i == OFF_PRIO + ADDR_W'(4 * l)) rdata_o = DATA_W'(prio_q[l]);
      if (addr_i == OFF_ENABLE) rdata_o = DATA_W'(en_q);
      if (addr_i == OFF_TYPE)   rdata_o = type_q;
      if (addr_i == OFF_PEND)   rdata_o = DATA_W'(pend_i);
      if (addr_i == OFF_THRESH) rdata_o = DATA_W'(thr_q);
    end else begin
      for (int k = 0; k < N_SWI; k++)
        if (addr_i == OFF_SWI + ADDR_W'(4 * k)) rdata_o = DATA_W'(swi_q[k]);
    end
  end

  assign map_o  = map_q;
  assign prio_o = prio_q;
  assign en_o   = en_q;
  assign thr_o  = thr_q;
  assign swi_o  = swi_q;
endmodule

// File: rtl/irq_line_fanin.sv
module irq_line_fanin #(
  parameter int unsigned N_SRC  = 62,
  parameter int unsigned LINE_W = 5,
  localparam int unsigned N_LINE = 1 << LINE_W
) (
  input  logic [N_SRC-1:0]  act_i,
  input  logic [N_SRC-1:0]  rise_i,
  input  logic [LINE_W-1:0] map_i [N_SRC],
  output logic [N_LINE-1:0] line_act_o,
  output logic [N_LINE-1:0] line_rise_o
);
  always_comb begin
    line_act_o  = '0;
    line_rise_o = '0;
    // line 0 means unrouted and stays clear
    for (int l = 1; l < N_LINE; l++) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (map_i[s] == LINE_W'(l)) begin
          line_act_o[l]  = line_act_o[l]  | act_i[s];
          line_rise_o[l] = line_rise_o[l] | rise_i[s];
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int unsigned LINE_W = 5,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned N_LINE = 1 << LINE_W
) (
  input  logic [N_LINE-1:0] pool_i,
  input  logic [PRIO_W-1:0] prio_i [N_LINE],
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o,
  output logic [N_LINE-1:0] grant_o
);
  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare: ties keep the lowest line
  always_comb begin
    valid_o = 1'b0;
    line_o  = '0;
    best    = '0;
    for (int l = 1; l < N_LINE; l++) begin
      if (pool_i[l] && (!valid_o || prio_i[l] > best)) begin
        valid_o = 1'b1;
        line_o  = LINE_W'(l);
        best    = prio_i[l];
      end
    end
  end

  assign grant_o = valid_o ? (N_LINE'(1) << line_o) : '0;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC    = 62,
  parameter int unsigned LINE_W   = 5,
  parameter int unsigned PRIO_W   = 4,
  parameter int unsigned N_SWI    = 4,
  parameter int unsigned SWI_BASE = 28,
  localparam int unsigned N_LINE  = 1 << LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic              reg_space_i,
  input  logic [11:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              core_mie_i,
  input  logic              irq_ack_i,
  output logic              irq_req_o,
  output logic [31:0]       irq_cause_o
);
  logic [LINE_W-1:0] map   [N_SRC];
  logic [PRIO_W-1:0] prio  [N_LINE];
  logic [N_LINE-1:0] en;
  logic [PRIO_W-1:0] thr;
  logic [N_SWI-1:0]  swi;
  logic [N_LINE-1:0] pend_q, pend_d;

  irq_reg_file #(
    .N_SRC(N_SRC), .LINE_W(LINE_W), .PRIO_W(PRIO_W), .N_SWI(N_SWI)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(reg_req_i), .we_i(reg_we_i), .space_i(reg_space_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .pend_i(pend_q),
    .map_o(map), .en_o(en), .prio_o(prio), .thr_o(thr), .swi_o(swi)
  );

  // software triggers OR into their fixed sources
  logic [N_SRC-1:0] src_eff, src_q, src_rise;
  always_comb begin
    src_eff = src_i;
    for (int k = 0; k < N_SWI; k++) src_eff[SWI_BASE + k] = src_i[SWI_BASE + k] | swi[k];
  end

  logic mie_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      mie_q <= 1'b0;
    end else begin
      src_q <= src_eff;
      mie_q <= core_mie_i;
    end
  end
  assign src_rise = src_eff & ~src_q;

  logic [N_LINE-1:0] line_act, line_rise;
  irq_line_fanin #(.N_SRC(N_SRC), .LINE_W(LINE_W)) u_fanin (
    .act_i(src_eff), .rise_i(src_rise), .map_i(map),
    .line_act_o(line_act), .line_rise_o(line_rise)
  );

  logic [N_LINE-1:0] eligible;
  for (genvar l = 0; l < N_LINE; l++) begin : g_elig
    assign eligible[l] = en[l] & (prio[l] > thr);
  end

  logic req_q;
  logic [31:0] cause_q;
  logic can_deliver, mie_rise;
  logic [N_LINE-1:0] pool, grant;
  logic win_valid;
  logic [LINE_W-1:0] win_line;

  assign mie_rise    = core_mie_i & ~mie_q;
  assign can_deliver = core_mie_i & ~req_q;
  assign pool = can_deliver
              ? ((line_rise | (mie_rise ? pend_q : '0)) & eligible)
              : '0;

  irq_prio_arbiter #(.LINE_W(LINE_W), .PRIO_W(PRIO_W)) u_arb (
    .pool_i(pool), .prio_i(prio),
    .valid_o(win_valid), .line_o(win_line), .grant_o(grant)
  );

  // pending drops when its line has no active source left
  assign pend_d = ((pend_q | line_rise) & line_act) & ~grant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      req_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (req_q && irq_ack_i) begin
        req_q <= 1'b0;
      end else if (win_valid) begin
        req_q   <= 1'b1;
        cause_q <= {1'b1, {(31 - LINE_W){1'b0}}, win_line};
      end
    end
  end

  assign irq_req_o   = req_q;
  assign irq_cause_o = cause_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned LINE_W = 5,
  localparam int unsigned N_LINE = 1 << LINE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              core_mie_i,
  input logic              irq_ack_i,
  input logic              irq_req_o,
  input logic [31:0]       irq_cause_o,
  input logic [N_LINE-1:0] pend_i
);
  a_r3_cause_format: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_cause_o[31] && irq_cause_o[30:LINE_W] == '0 &&
                   irq_cause_o[LINE_W-1:0] != '0));

  a_r9_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !irq_ack_i) |=> (irq_req_o && $stable(irq_cause_o)));

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_ack_i) |=> !irq_req_o);

  a_r5_mie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) |-> $past(core_mie_i));

  a_r6_line0_never_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i[0]);
endmodule

bind irq_router irq_router_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .core_mie_i(core_mie_i),
  .irq_ack_i(irq_ack_i), .irq_req_o(irq_req_o), .irq_cause_o(irq_cause_o),
  .pend_i(pend_q)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0, reg_space_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [61:0] src = '0;
  logic        core_mie = 1'b1;
  logic        irq_ack = 1'b0;
  logic        irq_req_o;
  logic [31:0] irq_cause_o;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_router dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_space_i(reg_space_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .src_i(src), .core_mie_i(core_mie), .irq_ack_i(irq_ack),
    .irq_req_o(irq_req_o), .irq_cause_o(irq_cause_o)
  );

  // {space, addr, wdata, expected readback}
  localparam int NV = 13;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'hFFFF_FFFF, 32'h0000_001F},
    {1'b0, 12'h0F4, 32'h0000_0023, 32'h0000_0003},
    {1'b0, 12'h104, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {1'b0, 12'h108, 32'h1234_5678, 32'h1234_5678},
    {1'b0, 12'h120, 32'h0000_00FF, 32'h0000_000F},
    {1'b0, 12'h114, 32'h0000_000F, 32'h0000_0000},
    {1'b0, 12'h194, 32'h0000_0037, 32'h0000_0007},
    {1'b0, 12'h10C, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b0, 12'h0F8, 32'h0000_0011, 32'h0000_0000},
    {1'b0, 12'h200, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b1, 12'h028, 32'h0000_0003, 32'h0000_0001},
    {1'b1, 12'h038, 32'h0000_0001, 32'h0000_0000},
    {1'b1, 12'h104, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sp, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_space_i = sp; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic sp, input logic [11:0] a, output logic [31:0] d);
    reg_req_i = 1'b0; reg_we_i = 1'b0; reg_space_i = sp; reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic chk_pend(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(1'b0, 12'h10C, v);
    chk(tag, v, exp);
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic mie_pulse_on();
    core_mie = 1'b0;
    tick();
    core_mie = 1'b1;
    tick();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    src = '0; core_mie = 1'b1; irq_ack = 1'b0;
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    chk("R1 req", {31'b0, irq_req_o}, 32'h0);
    chk("R1 cause", irq_cause_o, 32'h0);
    chk_pend("R1 pending", 32'h0);
    rd(1'b0, 12'h104, v); chk("R1 enable", v, 32'h0);
    rd(1'b0, 12'h194, v); chk("R1 thresh", v, 32'h0);
    rd(1'b0, 12'h014, v); chk("R1 map", v, 32'h0);

    // R2 / R10 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][76], VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][76], VEC[i][75:64], v);
      chk($sformatf("R2/R10 vec%0d", i), v, VEC[i][31:0]);
    end
    do_reset();

    // R3 immediate delivery: src5 -> line 3, prio 5
    wr(1'b0, 12'h014, 32'd3);
    wr(1'b0, 12'h120, 32'd5);
    wr(1'b0, 12'h104, 32'h8);
    src[5] = 1'b1; tick();
    chk("R3 req", {31'b0, irq_req_o}, 32'h1);
    chk("R3 cause", irq_cause_o, 32'h8000_0003);
    chk_pend("R3 not pending", 32'h0);

    // R9 hold, and new rise only pends
    tick(); tick();
    chk("R9 hold", {31'b0, irq_req_o}, 32'h1);
    wr(1'b0, 12'h018, 32'd4);
    wr(1'b0, 12'h124, 32'd2);
    wr(1'b0, 12'h104, 32'h18);
    src[6] = 1'b1; tick();
    chk_pend("R9 pend while outstanding", 32'h10);
    chk("R9 cause kept", irq_cause_o, 32'h8000_0003);
    ack();
    chk("R9 ack clears", {31'b0, irq_req_o}, 32'h0);
    tick();
    chk("R9 no redelivery", {31'b0, irq_req_o}, 32'h0);
    chk_pend("R9 still pending", 32'h10);

    // R8 rescan on global enable
    mie_pulse_on();
    chk("R8 cause line4", irq_cause_o, 32'h8000_0004);
    chk_pend("R8 cleared", 32'h0);
    ack();
    src[5] = 1'b0; src[6] = 1'b0; tick();

    // R4 strict threshold
    wr(1'b0, 12'h194, 32'd5);
    src[5] = 1'b1; tick();
    chk("R4 equal blocked", {31'b0, irq_req_o}, 32'h0);
    chk_pend("R4 pending", 32'h8);
    src[5] = 1'b0; tick();
    chk_pend("R7 single drop", 32'h0);
    wr(1'b0, 12'h194, 32'd4);
    src[5] = 1'b1; tick();
    chk("R4 one lower passes", irq_cause_o, 32'h8000_0003);
    ack();
    src[5] = 1'b0; tick();
    wr(1'b0, 12'h194, 32'd0);

    // R5 disabled line, then mie low
    wr(1'b0, 12'h104, 32'h10);
    src[5] = 1'b1; tick();
    chk("R5 disabled no req", {31'b0, irq_req_o}, 32'h0);
    chk_pend("R5 disabled pend", 32'h8);
    src[5] = 1'b0; tick();
    wr(1'b0, 12'h104, 32'h18);
    core_mie = 1'b0;
    src[5] = 1'b1; tick();
    chk("R5 mie low no req", {31'b0, irq_req_o}, 32'h0);
    chk_pend("R5 mie low pend", 32'h8);
    src[5] = 1'b0; tick();
    core_mie = 1'b1; tick();
    chk("R5 nothing to rescan", {31'b0, irq_req_o}, 32'h0);

    // R6 unrouted source
    src[7] = 1'b1; tick();
    chk("R6 no req", {31'b0, irq_req_o}, 32'h0);
    chk_pend("R6 no pend", 32'h0);
    src[7] = 1'b0;

    // R7 shared line 6 (disabled)
    wr(1'b0, 12'h028, 32'd6);
    wr(1'b0, 12'h02C, 32'd6);
    src[10] = 1'b1; tick();
    src[11] = 1'b1; tick();
    chk_pend("R7 shared set", 32'h40);
    src[10] = 1'b0; tick();
    chk_pend("R7 one left", 32'h40);
    src[11] = 1'b0; tick();
    chk_pend("R7 last gone", 32'h0);

    // R8 priority order and tie break
    core_mie = 1'b0;
    wr(1'b0, 12'h030, 32'd8);
    wr(1'b0, 12'h034, 32'd9);
    wr(1'b0, 12'h134, 32'd9);
    wr(1'b0, 12'h138, 32'd9);
    wr(1'b0, 12'h12C, 32'd15);
    wr(1'b0, 12'h104, 32'h318);
    src[5] = 1'b1; src[10] = 1'b1; src[12] = 1'b1; src[13] = 1'b1; tick();
    chk_pend("R8 all pending", 32'h348);
    core_mie = 1'b1; tick();
    chk("R8 tie lowest line", irq_cause_o, 32'h8000_0008);
    chk_pend("R8 after first", 32'h248);
    ack(); mie_pulse_on();
    chk("R8 second", irq_cause_o, 32'h8000_0009);
    ack(); mie_pulse_on();
    chk("R8 third", irq_cause_o, 32'h8000_0003);
    chk_pend("R8 disabled stays", 32'h40);
    ack(); mie_pulse_on();
    chk("R8 disabled not taken", {31'b0, irq_req_o}, 32'h0);
    src[5] = 1'b0; src[10] = 1'b0; src[12] = 1'b0; src[13] = 1'b0; tick();
    chk_pend("R8 cleanup", 32'h0);

    // R11 simultaneous rises
    src[5] = 1'b1; src[12] = 1'b1; src[13] = 1'b1; tick();
    chk("R11 best", irq_cause_o, 32'h8000_0008);
    chk_pend("R11 rest pend", 32'h208);
    ack();
    chk("R11 acked", {31'b0, irq_req_o}, 32'h0);
    src[5] = 1'b0; src[12] = 1'b0; src[13] = 1'b0; tick();

    // R10 software trigger on source 29 -> line 2
    wr(1'b0, 12'h074, 32'd2);
    wr(1'b0, 12'h11C, 32'd1);
    wr(1'b0, 12'h104, 32'h31C);
    core_mie = 1'b0;
    wr(1'b1, 12'h02C, 32'h1);
    rd(1'b1, 12'h02C, v); chk("R10 readback", v, 32'h1);
    tick();
    chk_pend("R10 raise pends", 32'h4);
    wr(1'b1, 12'h02C, 32'h0);
    tick();
    chk_pend("R10 lower clears", 32'h0);
    core_mie = 1'b1; tick();
    wr(1'b1, 12'h02C, 32'h1);
    tick();
    chk("R10 delivered", irq_cause_o, 32'h8000_0002);
    ack();
    wr(1'b1, 12'h02C, 32'h0);
    rd(1'b1, 12'h030, v); chk("R10 other trigger", v, 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule